// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block keeps an approximate recency record for every set of a set-associative cache and names the way to evict when asked. Each set holds a small binary decision tree: three bits for a 4-way set, one bit for a 2-way set. Each bit points toward the half of its subtree that was used more recently. The cache controller reports every access with a strobe, the set index and the way touched. The block then rewrites that set's tree in the following clock edge. When the controller needs to refill a line, it raises a replacement request for a set. One cycle later the block returns a registered victim way with a valid flag.

The number of sets and the associativity (2 or 4) are parameters. Tree state lives in a per-set register array that reset clears. A single set index serves both the access and the request in a cycle. When both name the same set, the victim comes from the tree as it stood before that cycle's update.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset, every tree bit of every set is 0, so a request to any set before any access returns way 0, and `victim_valid` is 0 while `rst` is high.
- R2: `victim_valid` is 1 in exactly the cycle after a cycle with `rep_req` high, and 0 otherwise.
- R3: In 4-way mode, the tree bits are root bit t0, left-pair bit t1 (ways 0/1) and right-pair bit t2 (ways 2/3). A bit value of 1 means the lower-numbered side was used more recently. The victim is picked as follows. If t0=0, the victim is way 1 when t1=1 and way 0 when t1=0. If t0=1, the victim is way 3 when t2=1 and way 2 when t2=0.
- R4: In 4-way mode, an access to way w updates the tree as follows:
  - t0 becomes 1 for w<2 and 0 otherwise.
  - For w<2, t1 becomes 1 for w=0 and 0 for w=1.
  - For w>=2, t2 becomes 1 for w=2 and 0 for w=3.
  - The child bit of the other pair keeps its value.
- R5: The way most recently accessed in a set is never the next victim returned for that set.
- R6: When an access and a request name the same set in one cycle, the returned victim reflects the tree before that access.
- R7: An access to one set leaves the victim of every other set unchanged.
- R8: In 2-way mode, each set holds one bit: 1 after an access to way 0, 0 after an access to way 1. The victim is the other way, way 1 when the bit is 1 and way 0 when it is 0.
- R9: With `acc_valid` low, no tree bit changes, whatever `acc_way` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | $clog2(NUM_SETS) | Set addressed by the access and the request |
| acc_valid | input | 1 | An access to `acc_way` of `set_idx` happened |
| acc_way | input | $clog2(WAYS) | Way that was accessed |
| rep_req | input | 1 | Request a victim for `set_idx` |
| victim_way | output | $clog2(WAYS) | Registered victim way, held between requests |
| victim_valid | output | 1 | `victim_way` answers the request of the previous cycle |

## Verification
The bench builds two instances with eight sets each, one at WAYS=4 and one at WAYS=2. Both are driven from the same inputs, and the 2-way copy sees only the low bit of the way. Eight sets are few enough that directed walks can visit every set after reset. Random traffic also lands repeatedly on the same sets. That reaches every tree pattern, same-cycle access/request collisions and untouched-neighbour cases in both variants within a few thousand cycles.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // 4-way tree: bit0 root, bit1 pair {0,1}, bit2 pair {2,3}; 1 = lower side more recent
  function automatic logic [1:0] tree4_pick(input logic [2:0] t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    else      return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] tree4_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n    = t;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

  // 2-way: single bit, 1 = way 0 more recent
  function automatic logic tree2_pick(input logic t);
    return t;
  endfunction

  function automatic logic tree2_touch(input logic w);
    return ~w;
  endfunction

endpackage

// File: rtl/plru_state_array.sv
module plru_state_array #(
  parameter int NUM_SETS = 64,
  parameter int SW       = 3,
  localparam int SIW     = $clog2(NUM_SETS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SIW-1:0] idx,
  input  logic           we,
  input  logic [SW-1:0]  wdata,
  output logic [SW-1:0]  rdata
);
  logic [SW-1:0] mem [NUM_SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SETS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/plru_next_state.sv
module plru_next_state #(
  parameter int WAYS  = 4,
  localparam int SW   = WAYS - 1,
  localparam int WW   = $clog2(WAYS)
) (
  input  logic [SW-1:0] cur,
  input  logic [WW-1:0] way,
  output logic [SW-1:0] nxt
);
  import plru_pkg::*;
  generate
    if (WAYS == 4) begin : g_four
      assign nxt = tree4_touch(cur, way);
    end else begin : g_two
      logic unused_cur;
      assign unused_cur = cur[0];
      assign nxt = tree2_touch(way[0]);
    end
  endgenerate
endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick #(
  parameter int WAYS  = 4,
  localparam int SW   = WAYS - 1,
  localparam int WW   = $clog2(WAYS)
) (
  input  logic [SW-1:0] cur,
  output logic [WW-1:0] victim
);
  import plru_pkg::*;
  generate
    if (WAYS == 4) begin : g_four
      assign victim = tree4_pick(cur);
    end else begin : g_two
      assign victim = tree2_pick(cur[0]);
    end
  endgenerate
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
  parameter int NUM_SETS = 64,
  parameter int WAYS     = 4,
  localparam int SIW     = $clog2(NUM_SETS),
  localparam int WW      = $clog2(WAYS),
  localparam int SW      = WAYS - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SIW-1:0] set_idx,
  input  logic           acc_valid,
  input  logic [WW-1:0]  acc_way,
  input  logic           rep_req,
  output logic [WW-1:0]  victim_way,
  output logic           victim_valid
);
  logic [SW-1:0] tree_cur;
  logic [SW-1:0] tree_nxt;
  logic [WW-1:0] pick;

  plru_state_array #(.NUM_SETS(NUM_SETS), .SW(SW)) u_state (
    .clk   (clk),
    .rst   (rst),
    .idx   (set_idx),
    .we    (acc_valid),
    .wdata (tree_nxt),
    .rdata (tree_cur)
  );

  plru_next_state #(.WAYS(WAYS)) u_next (
    .cur (tree_cur),
    .way (acc_way),
    .nxt (tree_nxt)
  );

  plru_victim_pick #(.WAYS(WAYS)) u_pick (
    .cur    (tree_cur),
    .victim (pick)
  );

  // Victim taken from pre-update state (R6), registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= rep_req;
      if (rep_req) victim_way <= pick;
    end
  end

  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    rep_req |=> victim_valid);

  a_r2_valid_only_after_req: assert property (@(posedge clk) disable iff (rst)
    !rep_req |=> !victim_valid);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !victim_valid);

  a_r5_recent_way_spared: assert property (@(posedge clk) disable iff (rst)
    (rep_req && $past(acc_valid) && !$past(rst) && set_idx == $past(set_idx))
      |=> victim_way != $past(acc_way, 2));
endmodule

// File: tb/tb_plru_victim_sel.sv
module tb_plru_victim_sel;
  localparam int NS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] set_idx = '0;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_way = '0;
  logic       rep_req = 1'b0;
  logic [1:0] v4;
  logic       vv4;
  logic [0:0] v2;
  logic       vv2;

  always #10 clk = ~clk;

  plru_victim_sel #(.NUM_SETS(NS), .WAYS(4)) dut (
    .clk(clk), .rst(rst), .set_idx(set_idx), .acc_valid(acc_valid),
    .acc_way(acc_way), .rep_req(rep_req), .victim_way(v4), .victim_valid(vv4));

  plru_victim_sel #(.NUM_SETS(NS), .WAYS(2)) dut2 (
    .clk(clk), .rst(rst), .set_idx(set_idx), .acc_valid(acc_valid),
    .acc_way(acc_way[0]), .rep_req(rep_req), .victim_way(v2), .victim_valid(vv2));

  int checks = 0;
  int fails  = 0;

  // bench models
  logic [2:0] m4 [NS];
  logic       m2 [NS];

  // scoreboard queues (one entry per driven cycle)
  int    q_valid[$];
  int    q_w4[$];
  int    q_w2[$];
  string q_tag[$];
  bit    armed = 0;

  function automatic int exp4(input logic [2:0] t);
    // R3: root 0 -> left pair, child picks less recent
    if (t[0] == 1'b0) return (t[1] == 1'b1) ? 1 : 0;
    return (t[2] == 1'b1) ? 3 : 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input bit av, input int w, input bit rq, input int s, input string tag);
    @(negedge clk);
    acc_valid = av;
    acc_way   = w[1:0];
    rep_req   = rq;
    set_idx   = s[2:0];
    q_valid.push_back(rq ? 1 : 0);
    q_w4.push_back(exp4(m4[s]));
    q_w2.push_back(m2[s] ? 1 : 0);
    q_tag.push_back(tag);
    armed = 1;
    if (av) begin
      // R4 model
      if (w < 2) begin m4[s][0] = 1'b1; m4[s][1] = (w == 0); end
      else       begin m4[s][0] = 1'b0; m4[s][2] = (w == 2); end
      m2[s] = ((w % 2) == 0); // R8 model
    end
  endtask

  // monitor
  always @(posedge clk) begin
    if (armed && q_valid.size() > 0) begin
      int ev, e4, e2;
      string tg;
      #5;
      ev = q_valid.pop_front();
      e4 = q_w4.pop_front();
      e2 = q_w2.pop_front();
      tg = q_tag.pop_front();
      chk(int'(vv4) == ev, {tg, " R2 valid4"}, int'(vv4), ev);
      chk(int'(vv2) == ev, {tg, " R2 valid2"}, int'(vv2), ev);
      if (ev == 1) begin
        chk(int'(v4) == e4, {tg, " way4"}, int'(v4), e4);
        chk(int'(v2) == e2, {tg, " R8 way2"}, int'(v2), e2);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m4[i] = 3'b000; m2[i] = 1'b0; end
    rep_req = 1'b1; // request held during reset must not show
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(vv4 == 1'b0, "R1 valid4 in reset", int'(vv4), 0);
    chk(vv2 == 1'b0, "R1 valid2 in reset", int'(vv2), 0);
    rep_req = 1'b0;
    rst = 1'b0;

    // R1: every set yields way 0 after reset
    for (int s = 0; s < NS; s++) step(0, 0, 1, s, "R1");
    // R3/R4: walk ways in set 2
    step(1, 0, 0, 2, "R4");
    step(0, 0, 1, 2, "R3 after w0");
    step(1, 2, 0, 2, "R4");
    step(0, 0, 1, 2, "R3 after w2");
    step(1, 1, 0, 2, "R4");
    step(0, 0, 1, 2, "R4 keep t2");
    step(1, 3, 0, 2, "R4");
    step(0, 0, 1, 2, "R4 keep t1");
    // R5: access then request each way
    for (int w = 0; w < 4; w++) begin
      step(1, w, 0, 5, "R5");
      step(0, 0, 1, 5, "R5");
    end
    // R6: same-cycle access and request
    step(1, 3, 1, 6, "R6");
    step(1, 0, 1, 6, "R6");
    step(0, 0, 1, 6, "R6");
    // R7: other sets unaffected
    step(1, 1, 0, 3, "R7");
    step(0, 0, 1, 4, "R7");
    step(0, 0, 1, 0, "R7");
    // R9: ignored way while acc_valid low
    step(0, 3, 0, 3, "R9");
    step(0, 2, 0, 3, "R9");
    step(0, 0, 1, 3, "R9");
    // random traffic
    for (int n = 0; n < 3000; n++)
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, NS - 1)), "R3 rand");
    step(0, 0, 0, 0, "R2 idle");
    step(0, 0, 0, 0, "R2 idle");
    @(negedge clk);
    while (q_valid.size() > 0) @(negedge clk);
    armed = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule